// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first keys a table of 2-bit counters on a 12-bit register of recent outcomes shared by all branches. The second keeps a 10-bit outcome history for each branch, selected by its address, and uses that history to index a table of 3-bit counters. A third table of 2-bit counters is also keyed on the shared history. It decides which of the two answers is presented.

A lookup is combinational. The fetch side drives a branch address and receives the guess in the same cycle, together with a snapshot of the two history values that produced it. When the branch resolves, the update port returns the address, the real outcome and that snapshot. The counters that were consulted are then trained at the next clock edge. Both histories advance only at resolution time, so no recovery of speculative history is needed.

Top module: `tbp_tournament`

## Requirements
- R1: After reset every 2-bit counter holds 1, every 3-bit counter holds 3 and both histories are zero, so every lookup predicts not-taken with an all-zero snapshot.
- R2: Each update shifts the outcome into bit 0 of the shared 12-bit history and drops the oldest bit; a cycle without an update leaves it unchanged. The shared history appears in snapshot bits [21:10].
- R3: Each update shifts the outcome into bit 0 of the local history entry selected by the update address. That entry appears in snapshot bits [9:0] on a lookup of the same address.
- R4: A 2-bit counter steps up on a taken outcome and down otherwise, saturating at 0 and 3. Values 2 and 3 mean taken.
- R5: A 3-bit counter steps up on taken and down otherwise, saturating at 0 and 7. Values 4 and above mean taken.
- R6: The chooser entry selected by the shared history picks the global answer when it holds 2 or 3, and the local answer otherwise. The entry changes only when the two components disagree. It steps up when the global answer was right and down when the local answer was right.
- R7: The prediction and snapshot follow the lookup address with no clock. An update is visible to lookups from the next clock edge on.
- R8: An update trains the global counter and the chooser entry at the snapshot's shared history, and the local counter at the snapshot's local history. It does not use the current history values. The local history entry is selected by folding the address: bit i of the address is XORed into index bit i mod 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| lk_snap | output | 22 | Histories used for this guess: shared [21:10], local [9:0] |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_snap | input | 22 | Snapshot returned from the lookup of that branch |

## Verification
The hardest case to reach is a chooser entry that leaves its weakly-local reset state and then hands control to the global table. That only happens after repeated disagreements at the same shared-history value in which the global answer was right. The stimulus interleaves a fixed periodic branch with pseudo-random traffic, so both tables hold partly trained states and disagreements pile up. A bench model predicts every lookup, including which component the chooser selects. A separate update is replayed with a stale snapshot to show that training follows the returned histories.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  // one saturating step of an up/down counter bounded by [0, top]
  function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                          input logic [7:0] top,
                                          input logic       up);
    if (up) return (cur == top) ? cur : cur + 8'd1;
    else    return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction
endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
  parameter int IDX_W   = 12,
  parameter int CNT_W   = 2,
  parameter int RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_pred,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up,
  output logic             wr_pred
);
  import tbp_pkg::*;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] MAXV = '1;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] wr_cnt, wr_nxt;

  assign wr_cnt  = mem[wr_idx];
  assign wr_nxt  = CNT_W'(sat_step(8'(wr_cnt), 8'(MAXV), wr_up));
  assign rd_pred = mem[rd_idx][CNT_W-1];
  assign wr_pred = wr_cnt[CNT_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CNT_W'(RST_VAL);
    end else if (wr_en) begin
      mem[wr_idx] <= wr_nxt;
    end
  end

  // R4 / R5: saturation at the top and bottom
  p_sat_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_up && wr_cnt == MAXV |=> mem[$past(wr_idx)] == MAXV);
  p_sat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_up && wr_cnt == '0 |=> mem[$past(wr_idx)] == '0);
  // R5: unsaturated upward step is exactly one
  p_step_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_up && wr_cnt != MAXV |=> mem[$past(wr_idx)] == CNT_W'($past(wr_cnt) + 1'b1));
  // R7 / R6: an entry not written keeps its value
  p_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> mem[$past(wr_idx)] == $past(wr_cnt));
endmodule

// File: rtl/tbp_lhist.sv
module tbp_lhist #(
  parameter int IDX_W = 10,
  parameter int H_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [H_W-1:0]   rd_hist,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;
  logic [H_W-1:0] mem [DEPTH];

  assign rd_hist = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= {mem[wr_idx][H_W-2:0], wr_taken};
    end
  end

  p_lhist_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)][0] == $past(wr_taken)
           && mem[$past(wr_idx)][H_W-1:1] == $past(mem[wr_idx][H_W-2:0]));
endmodule

// File: rtl/tbp_tournament.sv
module tbp_tournament #(
  parameter int PC_W = 32,
  parameter int GH_W = 12,
  parameter int LA_W = 10,
  parameter int LH_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      lk_pc,
  output logic                 pred_taken,
  output logic [GH_W+LH_W-1:0] lk_snap,
  input  logic                 up_valid,
  input  logic [PC_W-1:0]      up_pc,
  input  logic                 up_taken,
  input  logic [GH_W+LH_W-1:0] up_snap
);
  logic [GH_W-1:0] ghist;
  logic [LA_W-1:0] lk_lidx, up_lidx;
  logic [LH_W-1:0] lk_lhist, up_lhist;
  logic [GH_W-1:0] up_ghist;
  logic g_lk, l_lk, c_lk, g_up, l_up, c_up_unused;
  logic disagree, glob_right;

  // address folding: bit i lands in index bit i mod LA_W
  always_comb begin
    lk_lidx = '0;
    up_lidx = '0;
    for (int i = 0; i < PC_W; i++) begin
      lk_lidx[i % LA_W] = lk_lidx[i % LA_W] ^ lk_pc[i];
      up_lidx[i % LA_W] = up_lidx[i % LA_W] ^ up_pc[i];
    end
  end

  assign up_ghist   = up_snap[LH_W +: GH_W];
  assign up_lhist   = up_snap[LH_W-1:0];
  assign lk_snap    = {ghist, lk_lhist};
  assign disagree   = g_up ^ l_up;
  assign glob_right = (g_up == up_taken);
  assign pred_taken = c_lk ? g_lk : l_lk;

  always_ff @(posedge clk) begin
    if (!rst_n)        ghist <= '0;
    else if (up_valid) ghist <= {ghist[GH_W-2:0], up_taken};
  end

  tbp_lhist #(.IDX_W(LA_W), .H_W(LH_W)) u_lhist (
    .clk, .rst_n, .rd_idx(lk_lidx), .rd_hist(lk_lhist),
    .wr_en(up_valid), .wr_idx(up_lidx), .wr_taken(up_taken));

  tbp_ctr_table #(.IDX_W(GH_W), .CNT_W(2), .RST_VAL(1)) u_glob (
    .clk, .rst_n, .rd_idx(ghist), .rd_pred(g_lk),
    .wr_en(up_valid), .wr_idx(up_ghist), .wr_up(up_taken), .wr_pred(g_up));

  tbp_ctr_table #(.IDX_W(LH_W), .CNT_W(3), .RST_VAL(3)) u_loc (
    .clk, .rst_n, .rd_idx(lk_lhist), .rd_pred(l_lk),
    .wr_en(up_valid), .wr_idx(up_lhist), .wr_up(up_taken), .wr_pred(l_up));

  tbp_ctr_table #(.IDX_W(GH_W), .CNT_W(2), .RST_VAL(1)) u_chs (
    .clk, .rst_n, .rd_idx(ghist), .rd_pred(c_lk),
    .wr_en(up_valid && disagree), .wr_idx(up_ghist), .wr_up(glob_right),
    .wr_pred(c_up_unused));

  p_ghist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist[0] == $past(up_taken) && ghist[GH_W-1:1] == $past(ghist[GH_W-2:0]));
  p_ghist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));
  // R6: when both components agree the chosen answer equals either one
  p_agree_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (g_lk == l_lk) |-> pred_taken == g_lk);
endmodule

// File: tb/tbp_tournament_tb.sv
module tbp_tournament_tb;
  logic clk = 0, rst_n = 0;
  logic [31:0] lk_pc = 0, up_pc = 0;
  logic up_valid = 0, up_taken = 0;
  logic [21:0] up_snap = 0;
  logic pred_taken;
  logic [21:0] lk_snap;

  always #4 clk = ~clk;

  tbp_tournament u_dut (.clk, .rst_n, .lk_pc, .pred_taken, .lk_snap,
                        .up_valid, .up_pc, .up_taken, .up_snap);

  int n_chk = 0, n_bad = 0;
  int gpt[4096], cht[4096], lpt[1024], lht[1024];
  int m_gh = 0;

  typedef struct { bit pred; logic [21:0] snap; string tag; } exp_t;
  exp_t q[$];
  event ev_chk;

  function automatic int fold(logic [31:0] pc);
    int r = 0;
    for (int k = 0; k < 32; k += 10) r = r ^ int'((pc >> k) & 32'h3FF);
    return r;
  endfunction

  function automatic int bump(int v, int hi, bit up);
    if (up) return (v < hi) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  function automatic logic [21:0] m_snap(logic [31:0] pc);
    return 22'((m_gh << 10) | lht[fold(pc)]);
  endfunction

  function automatic bit m_pred(logic [31:0] pc);
    bit gp = gpt[m_gh] >= 2;
    bit lp = lpt[lht[fold(pc)]] >= 4;
    return (cht[m_gh] >= 2) ? gp : lp;
  endfunction

  function automatic void m_update(logic [31:0] pc, bit tk, logic [21:0] sn);
    int gi = int'(sn >> 10);
    int li = int'(sn & 22'h3FF);
    bit gp = gpt[gi] >= 2;
    bit lp = lpt[li] >= 4;
    if (gp != lp) cht[gi] = bump(cht[gi], 3, gp == tk);
    gpt[gi] = bump(gpt[gi], 3, tk);
    lpt[li] = bump(lpt[li], 7, tk);
    lht[fold(pc)] = ((lht[fold(pc)] << 1) | int'(tk)) & 'h3FF;
    m_gh = ((m_gh << 1) | int'(tk)) & 'hFFF;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of lookup plus optional update
  task automatic step(logic [31:0] pc, bit up, logic [31:0] upc, bit tk,
                      logic [21:0] sn, string tag);
    exp_t e;
    @(negedge clk);
    lk_pc = pc; up_valid = up; up_pc = upc; up_taken = tk; up_snap = sn;
    e.pred = m_pred(pc); e.snap = m_snap(pc); e.tag = tag;
    q.push_back(e);
    ->ev_chk;
    @(posedge clk);
    if (up) m_update(upc, tk, sn);
  endtask

  task automatic branch(logic [31:0] pc, bit tk, string tag);
    step(pc, 1, pc, tk, m_snap(pc), tag);
  endtask

  // monitor
  initial forever begin
    exp_t e;
    @(ev_chk);
    #1;
    e = q.pop_front();
    check(pred_taken == e.pred, e.tag, "prediction", pred_taken, e.pred);
    check(lk_snap == e.snap, e.tag, "snapshot", lk_snap, e.snap);
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    for (int i = 0; i < 4096; i++) begin gpt[i] = 1; cht[i] = 1; end
    for (int i = 0; i < 1024; i++) begin lpt[i] = 3; lht[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state, several addresses, no update
    for (int i = 0; i < 4; i++) step(32'h1000 + i * 32'h404, 0, 0, 0, 0, "R1");
    @(negedge clk) #1;
    check(pred_taken == 0 && lk_snap == 0, "R1", "reset lookup", {pred_taken, lk_snap}, 0);

    // R2/R3/R5: always-taken branch trains local side to taken
    for (int i = 0; i < 30; i++) branch(32'h0000_4A20, 1, "R5");
    step(32'h0000_4A20, 0, 0, 0, 0, "R3");
    @(negedge clk) #1;
    check(lk_snap == 22'h3FFFFF, "R2", "histories all ones", lk_snap, 22'h3FFFFF);
    check(pred_taken == 1, "R5", "trained taken", pred_taken, 1);

    // R7: idle cycles leave snapshot unchanged
    for (int i = 0; i < 3; i++) step(32'h0000_4A20, 0, 0, 0, 0, "R7");

    // R4: not-taken run drives counters to floor
    for (int i = 0; i < 30; i++) branch(32'h0000_4A20, 0, "R4");
    @(negedge clk) #1;
    check(pred_taken == 0, "R4", "trained not-taken", pred_taken, 0);

    // R3: alternating branch learned through its own history
    for (int i = 0; i < 60; i++) branch(32'h0008_1100, i[0], "R3");

    // R6: periodic branch mixed with pseudo-random traffic
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (i % 2 == 0) branch(32'h0002_0040, (i % 6) != 4, "R6");
      else            branch({20'h0, lfsr[11:0]} & 32'h3C0, lfsr[13], "R6");
    end
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      branch(32'h0003_0000 + (lfsr[2:0] * 32'h10), lfsr[2], "R6");
    end

    // R8: updates carrying stale or unrelated snapshots
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(32'h0002_0040, 1, 32'h0002_0040, lfsr[4], lfsr[21:0], "R8");
      step(32'h0002_0040, 0, 0, 0, 0, "R8");
    end
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      branch(lfsr & 32'hFFFF_FFFC, lfsr[7], "R8");
    end

    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule